// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block holds the status flags of a simple asynchronous serial port and produces its interrupt request. The transmit and receive datapaths send it single-cycle event pulses: the holding byte was handed to the transmit shifter, a frame finished sending, a received byte reached the readable data register, and the line went idle. From these pulses the block keeps four flags: holding empty, transmit complete, receive ready and idle seen. It shows them in the upper half of an 8-bit read-only status word.

Software never clears a flag directly. It first reads the status word, and this arms a clear and records which flags were set at that moment. The next access to the data register then clears the recorded flags of one group. A data write clears the transmit group and a data read clears the receive group. An interrupt enable for each flag selects which flags drive the single registered interrupt line. The lower four status bits are kept for error flags and read as zero in this block. It also tells the transmit side when the holding register has content that may be handed to the shifter.

Top module: `serial_flag_ctl`

## Requirements
- R1: After reset the status word is 0xC0, `irq` is 0 and `tx_hold_full` is 0.
- R2: Status bit positions: bit 7 holding-empty, bit 6 transmit-complete, bit 5 receive-ready, bit 4 idle-seen. Bits 3..0 always read 0.
- R3: A `ev_tx_load` pulse while holding-empty is 0 sets holding-empty one edge later. While holding-empty is 1 the pulse is ignored. `tx_hold_full` always equals the inverse of holding-empty.
- R4: A `ev_tx_done` pulse sets transmit-complete only when `tx_kind` is 2'b00 (data frame). The values 2'b01 (preamble), 2'b10 (break) and 2'b11 leave it unchanged.
- R5: A `ev_rx_load` pulse sets receive-ready.
- R6: An `ev_idle` pulse sets idle-seen only while the idle detector is armed. The detector is armed at reset and disarmed when idle-seen gets set. Only an `ev_rx_load` re-arms it, and `ev_rx_load` takes priority when both pulses arrive in the same cycle.
- R7: A status read (`bus_rd` with `bus_addr`=0) arms the clear and records the flags set in that cycle. The next data access (`bus_addr`=1) completes the clear and always disarms. A data write clears the recorded holding-empty and transmit-complete flags. A data read clears the recorded receive-ready and idle-seen flags. A write to address 0 changes nothing.
- R8: A flag that was 0 at the arming read is not cleared by the completing access. A data access that is not armed clears nothing. A data read leaves the transmit group unchanged, and a data write leaves the receive group unchanged.
- R9: When a set event and a completing clear hit the same flag in the same cycle, the flag ends up 1.
- R10: `irq` is registered. After each edge it equals the OR, taken over the cycle before that edge, of each flag ANDed with its enable: `irq_en[3]` holding-empty, `[2]` transmit-complete, `[1]` receive-ready, `[0]` idle-seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_load | input | 1 | Holding byte handed to the transmit shifter |
| ev_tx_done | input | 1 | Transmit frame finished |
| tx_kind | input | 2 | Kind of the finished frame: 0 data, 1 preamble, 2 break |
| ev_rx_load | input | 1 | Received byte placed in the readable data register |
| ev_idle | input | 1 | Idle line detected |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_addr | input | 1 | 0 status word, 1 data register |
| irq_en | input | 4 | Per-flag interrupt enables |
| status | output | 8 | Status word |
| tx_hold_full | output | 1 | Holding register has content for the shifter |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a set event that lands in the same cycle as the arming status read. The flag then becomes 1 but is not recorded, so it must survive the completing data access. The collision of a set with a completing clear is just as hard to reach. Directed sequences drive receive and transmit events exactly on the arming read and on the completing access. A long run of seeded random bus and event traffic is then compared every cycle against a spec model in the bench. The random traffic includes status reads that are never completed, stray data accesses and repeated idle pulses.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
   localparam int NFLAG   = 4;
   localparam int FI_IDLE = 0;
   localparam int FI_RDRF = 1;
   localparam int FI_TC   = 2;
   localparam int FI_TDRE = 3;
   localparam logic [NFLAG-1:0] WR_GROUP = 4'b1100;
   localparam logic [NFLAG-1:0] RD_GROUP = 4'b0011;
   localparam logic [NFLAG-1:0] FLAG_RST = 4'b1100;
   typedef enum logic [1:0] {
      TXK_DATA     = 2'd0,
      TXK_PREAMBLE = 2'd1,
      TXK_BREAK    = 2'd2,
      TXK_RSVD     = 2'd3
   } txkind_e;
endpackage

// File: rtl/sflag_bit.sv
module sflag_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o); // R9
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o); // R7
endmodule

// File: rtl/sflag_clrseq.sv
module sflag_clrseq
   import sflag_pkg::*;
#(
   parameter int N = NFLAG
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stat_rd_i,
   input  logic         data_rd_i,
   input  logic         data_wr_i,
   input  logic [N-1:0] flags_i,
   output logic [N-1:0] clr_o
);
   logic         arm_q;
   logic [N-1:0] snap_q;
   logic [N-1:0] wr_part, rd_part;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         snap_q <= '0;
      end else if (stat_rd_i) begin
         arm_q  <= 1'b1;
         snap_q <= flags_i;
      end else if (data_rd_i || data_wr_i) begin
         arm_q  <= 1'b0;
      end
   end

   always_comb begin
      wr_part = (arm_q && data_wr_i) ? (snap_q & WR_GROUP) : '0;
      rd_part = (arm_q && data_rd_i) ? (snap_q & RD_GROUP) : '0;
      clr_o   = wr_part | rd_part;
   end

   AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q |-> (clr_o == '0)); // R8
   AST_CLR_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o & ~flags_i) == '0); // R8
   AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i || data_wr_i) && !stat_rd_i |=> !arm_q); // R7
endmodule

// File: rtl/sflag_irq.sv
module sflag_irq #(
   parameter int N      = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags_i,
   input  logic [N-1:0] en_i,
   output logic         irq_o
);
   logic any_w;
   assign any_w = |(flags_i & en_i);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= any_w;
      end
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !any_w |=> !irq_o); // R10
      AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
         any_w |=> irq_o); // R10
   end else begin : g_comb
      assign irq_o = any_w;
   end
endmodule

// File: rtl/serial_flag_ctl.sv
module serial_flag_ctl
   import sflag_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_tx_load,
   input  logic              ev_tx_done,
   input  logic [1:0]        tx_kind,
   input  logic              ev_rx_load,
   input  logic              ev_idle,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [NFLAG-1:0]  irq_en,
   output logic [STAT_W-1:0] status,
   output logic              tx_hold_full,
   output logic              irq
);
   localparam int ERR_W = STAT_W - NFLAG;

   if (ERR_W < 1) begin : g_bad_width
      $error("serial_flag_ctl: STAT_W must exceed the flag count");
   end

   logic [NFLAG-1:0] flag_q, set_w, clr_w;
   logic             idle_arm_q;
   logic             stat_rd, data_rd, data_wr;
   txkind_e          kind;

   assign kind    = txkind_e'(tx_kind);
   assign stat_rd = bus_rd && !bus_addr;
   assign data_rd = bus_rd &&  bus_addr;
   assign data_wr = bus_wr &&  bus_addr;

   always_comb begin
      set_w          = '0;
      set_w[FI_TDRE] = ev_tx_load && !flag_q[FI_TDRE];
      set_w[FI_TC]   = ev_tx_done && (kind == TXK_DATA);
      set_w[FI_RDRF] = ev_rx_load;
      set_w[FI_IDLE] = ev_idle && idle_arm_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  idle_arm_q <= 1'b1;
      else if (ev_rx_load)         idle_arm_q <= 1'b1;
      else if (set_w[FI_IDLE])     idle_arm_q <= 1'b0;
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      sflag_bit #(.RST_VAL(FLAG_RST[i])) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_w[i]),
         .clr_i (clr_w[i]),
         .q_o   (flag_q[i])
      );
   end

   sflag_clrseq #(.N(NFLAG)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .data_wr_i (data_wr),
      .flags_i   (flag_q),
      .clr_o     (clr_w)
   );

   sflag_irq #(.N(NFLAG), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flag_q),
      .en_i    (irq_en),
      .irq_o   (irq)
   );

   assign status       = {flag_q, {ERR_W{1'b0}}};
   assign tx_hold_full = !flag_q[FI_TDRE];

   AST_TC_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[FI_TC] && ev_tx_done && kind != TXK_DATA) |=> !flag_q[FI_TC]); // R4
   AST_TDRE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[FI_TDRE]) |-> $past(ev_tx_load)); // R3
   AST_IDLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_arm_q && !flag_q[FI_IDLE]) |=> !flag_q[FI_IDLE]); // R6
   AST_RDRF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_load |=> flag_q[FI_RDRF]); // R5
   AST_ERR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      status[ERR_W-1:0] == '0); // R2
endmodule

// File: tb/tb_serial_flag_ctl.sv
module tb_serial_flag_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_tx_load = 0, ev_tx_done = 0, ev_rx_load = 0, ev_idle = 0;
   logic [1:0] tx_kind = 0;
   logic bus_rd = 0, bus_wr = 0, bus_addr = 0;
   logic [3:0] irq_en = 0;
   logic [7:0] status;
   logic tx_hold_full, irq;

   int checks = 0, fails = 0;
   bit done = 0;

   // spec model: flags [3]=TDRE [2]=TC [1]=RDRF [0]=IDLE
   logic [3:0] m_flag;
   logic       m_arm, m_iarm, m_irq;
   logic [3:0] m_snap;

   always #5 clk = ~clk;

   serial_flag_ctl dut (
      .clk(clk), .rst_n(rst_n), .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done),
      .tx_kind(tx_kind), .ev_rx_load(ev_rx_load), .ev_idle(ev_idle),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq_en(irq_en),
      .status(status), .tx_hold_full(tx_hold_full), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] m_status();
      return {m_flag, 4'b0000};
   endfunction

   task automatic model_reset();
      m_flag = 4'b1100; m_arm = 0; m_snap = 0; m_iarm = 1; m_irq = 0;
   endtask

   task automatic model_step();
      logic sr, dr, dw;
      logic [3:0] clr, set, old;
      sr = bus_rd && !bus_addr;
      dr = bus_rd && bus_addr;
      dw = bus_wr && bus_addr;
      old = m_flag;
      clr = 0;
      if (m_arm && dw) clr |= m_snap & 4'b1100;
      if (m_arm && dr) clr |= m_snap & 4'b0011;
      set = {ev_tx_load && !old[3], ev_tx_done && tx_kind == 2'b00, ev_rx_load, ev_idle && m_iarm};
      m_flag = (old & ~clr) | set;
      if (sr) begin m_arm = 1; m_snap = old; end
      else if (dr || dw) m_arm = 0;
      if (ev_rx_load) m_iarm = 1;
      else if (set[0]) m_iarm = 0;
      m_irq = |(old & irq_en);
   endtask

   // called at a negedge with inputs driven; returns at the next negedge
   task automatic step(input string req);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(req, status, m_status());
      chk("R3 tx_hold_full", {7'b0, tx_hold_full}, {7'b0, ~m_flag[3]});
      chk("R10 irq", {7'b0, irq}, {7'b0, m_irq});
   endtask

   task automatic idle_in();
      ev_tx_load = 0; ev_tx_done = 0; tx_kind = 0; ev_rx_load = 0; ev_idle = 0;
      bus_rd = 0; bus_wr = 0; bus_addr = 0;
   endtask

   task automatic stat_read();
      idle_in(); bus_rd = 1; bus_addr = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R1 actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset status", status, 8'hC0);
      chk("R1 reset irq", {7'b0, irq}, 8'h00);
      chk("R1 reset tx_hold_full", {7'b0, tx_hold_full}, 8'h00);
      rst_n = 1;

      // R4: preamble and break do not set TC; clear TC first via status read + data write
      stat_read(); step("R7 arm");
      idle_in(); bus_wr = 1; bus_addr = 1; step("R7 write clears TDRE and TC");
      chk("R7 after write clear", status, 8'h00);
      idle_in(); ev_tx_done = 1; tx_kind = 2'b01; step("R4 preamble");
      chk("R4 preamble no TC", status, 8'h00);
      idle_in(); ev_tx_done = 1; tx_kind = 2'b10; step("R4 break");
      chk("R4 break no TC", status, 8'h00);
      idle_in(); ev_tx_done = 1; tx_kind = 2'b00; step("R4 data frame");
      chk("R4 data sets TC", status, 8'h40);

      // R3: holding load while empty flag clear sets it
      idle_in(); ev_tx_load = 1; step("R3 load");
      chk("R3 TDRE set", status, 8'hC0);

      // R5/R6: idle then rx, idle blocked until rx
      idle_in(); ev_idle = 1; step("R6 idle");
      chk("R6 idle set", status, 8'hD0);
      stat_read(); step("R7 arm rx");
      idle_in(); bus_rd = 1; bus_addr = 1; step("R7 read clears idle");
      chk("R8 read keeps tx group", status, 8'hC0);
      idle_in(); ev_idle = 1; step("R6 blocked");
      chk("R6 idle blocked", status, 8'hC0);
      idle_in(); ev_rx_load = 1; step("R5 rx");
      chk("R5 rdrf set", status, 8'hE0);
      idle_in(); ev_idle = 1; step("R6 rearmed");
      chk("R6 idle rearmed", status, 8'hF0);

      // R8: set in the same cycle as the arming read survives
      stat_read(); step("R8 arm");
      idle_in(); bus_rd = 1; bus_addr = 1; step("R8 clear rx group");
      chk("R8 rx group cleared", status, 8'hC0);
      stat_read(); ev_rx_load = 1; step("R8 set on arming read");
      idle_in(); bus_rd = 1; bus_addr = 1; step("R8 complete");
      chk("R8 late flag survives", status, 8'hE0);
      idle_in(); bus_rd = 1; bus_addr = 1; step("R8 unarmed read");
      chk("R8 unarmed read clears nothing", status, 8'hE0);
      idle_in(); bus_wr = 1; bus_addr = 0; step("R7 status write ignored");
      chk("R7 status write no effect", status, 8'hE0);

      // R9: set and clear collide
      stat_read(); step("R9 arm");
      idle_in(); bus_rd = 1; bus_addr = 1; ev_rx_load = 1; step("R9 collide");
      chk("R9 set wins", status, 8'hE0);

      // R10: interrupt enables
      idle_in(); irq_en = 4'b0010; step("R10 en rx");
      idle_in(); step("R10 irq high");
      chk("R10 irq from RDRF", {7'b0, irq}, 8'h01);
      irq_en = 4'b0001; step("R10 en idle only");
      idle_in(); step("R10 irq low");
      chk("R10 irq masked", {7'b0, irq}, 8'h00);

      // random traffic
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 4000; i++) begin
         int r;
         idle_in();
         r = $urandom_range(0, 9);
         ev_tx_load = ($urandom_range(0, 3) == 0);
         ev_tx_done = ($urandom_range(0, 3) == 0);
         tx_kind    = 2'($urandom_range(0, 3));
         ev_rx_load = ($urandom_range(0, 5) == 0);
         ev_idle    = ($urandom_range(0, 3) == 0);
         if (r < 3)      begin bus_rd = 1; bus_addr = 0; end
         else if (r < 5) begin bus_rd = 1; bus_addr = 1; end
         else if (r < 7) begin bus_wr = 1; bus_addr = 1; end
         else if (r == 7) begin bus_wr = 1; bus_addr = 0; end
         if ($urandom_range(0, 15) == 0) irq_en = 4'($urandom_range(0, 15));
         step("R8 random flags");
         chk("R2 low bits zero", {4'b0, status[3:0]}, 8'h00);
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule